// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Queueing

This block serialises 8-bit or 9-bit characters onto a single line. A one-entry data buffer takes a character from the bus side. When the shift register is free, the buffer contents move into it, and the character goes out as a start bit, the data bits least significant first, and a stop bit. Optional hardware parity replaces the top data bit with a computed even or odd parity bit. The bit rate comes from an external tick, and every bit lasts a fixed number of ticks.

Two queued characters exist besides data. Dropping the enable and raising it again while a frame is on the line queues one idle character, which is a whole frame length of ones. A break request queues a frame length of zeros followed by one high bit. Once the enable is dropped, the transmitter keeps the pin until everything pending has gone out. Loop and single-wire selections then decide whether the pad is actually driven. Two status flags, buffer-empty and transmission-complete, each come with a request output that is gated by its own enable.

Top module: `uart_tx_idleq`

## Requirements
- R1: After reset the line is high, the output enable is low, buffer-empty and transmission-complete are 1, and both requests are 0.
- R2: A data frame is one start bit (0), then 8 data bits (nine_bit=0) or 9 data bits (nine_bit=1) least significant first, then one stop bit (1). Each bit lasts OS baud ticks (OS=16).
- R3: With par_en=1 the top data bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is replaced by parity over the lower data bits. par_odd=0 makes the total count of ones, parity included, even. par_odd=1 makes it odd.
- R4: A write pulse clears buffer-empty. The buffer moves into the shift register, which sets buffer-empty again, only while the transmitter owns the pin and the shift register is idle.
- R5: Transmission-complete is 1 only while the shift register is idle, the buffer is empty and no idle or break character is queued.
- R6: A 0-to-1 transition of tx_en while a frame is being shifted queues one idle character (frame length of ones). It is sent right after the current frame and before the buffered data.
- R7: After tx_en falls, the transmitter keeps ownership (ser_oe=1 outside loop mode) until all pending data, idle and break characters are sent. Ownership then releases.
- R8: A brk_req pulse with tx_en=1 sends a frame length of zeros (10 or 11 bits, i.e. 160 or 176 ticks), then one high bit.
- R9: With loop_mode=1 and rx_src=0, ser_oe is 0 even if the transmitter owns the pin. With loop_mode=1 and rx_src=1, ser_oe follows sw_dir. With loop_mode=0, ser_oe shows ownership.
- R10: irq_buf is 1 exactly when int_buf_en=1 and buffer-empty is 1. irq_done is 1 exactly when int_done_en=1 and transmission-complete is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, OS ticks per bit |
| tx_en | input | 1 | Transmitter enable |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| nine_bit | input | 1 | 0 eight data bits, 1 nine data bits |
| loop_mode | input | 1 | Loop mode select |
| rx_src | input | 1 | Receiver source select, 1 selects single-wire |
| sw_dir | input | 1 | Single-wire direction, 1 drives the line |
| int_buf_en | input | 1 | Buffer-empty request enable |
| int_done_en | input | 1 | Transmission-complete request enable |
| wr_stb | input | 1 | Buffer write pulse |
| wr_data | input | 9 | Character to write |
| brk_req | input | 1 | Break request pulse |
| ser_out | output | 1 | Serial line, high when idle |
| ser_oe | output | 1 | Pad output enable |
| buf_empty | output | 1 | Buffer-empty flag |
| tx_done | output | 1 | Transmission-complete flag |
| irq_buf | output | 1 | Gated buffer-empty request |
| irq_done | output | 1 | Gated transmission-complete request |

## Verification
A write changes buffer-empty one edge later. If the transmitter owns the pin, the start bit appears one edge after that. Ownership follows tx_en one edge late. A queued idle, break or buffered character starts one edge after the previous frame's last bit ends. With a tick on every cycle, the bench finds each start bit and then samples the middle of every bit, 8 cycles into it plus whole 16-cycle strides. For each one-edge frame gap it adds one cycle, so every sample sits 7 cycles clear of any bit edge. Flags and ownership are read on falling edges, at least two edges after the event that moves them.

// File: rtl/uart_tx_idleq.sv
module uart_tx_idleq #(
  parameter int OS = 16,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          tx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          nine_bit,
  input  logic          loop_mode,
  input  logic          rx_src,
  input  logic          sw_dir,
  input  logic          int_buf_en,
  input  logic          int_done_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          brk_req,
  output logic          ser_out,
  output logic          ser_oe,
  output logic          buf_empty,
  output logic          tx_done,
  output logic          irq_buf,
  output logic          irq_done
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OS);
  localparam int BW = $clog2(FW + 1);
  localparam logic [BW-1:0] LEN_SHORT = BW'(DW + 1);
  localparam logic [BW-1:0] LEN_LONG  = BW'(DW + 2);

  logic [DW-1:0] buf_q;
  logic          empty_q, busy, own, en_d, idle_q, brk_q;
  logic [FW-1:0] sh;
  logic [BW-1:0] left;
  logic [CW-1:0] tcnt;

  logic [BW-1:0] flen;
  logic [DW-1:0] lowmask, dsel;
  logic [FW-1:0] frame;
  logic          par, pend;

  assign flen    = nine_bit ? LEN_LONG : LEN_SHORT;
  assign lowmask = nine_bit ? {1'b0, {(DW-1){1'b1}}} : {2'b00, {(DW-2){1'b1}}};
  assign par     = (^(buf_q & lowmask)) ^ par_odd;

  always_comb begin
    if (nine_bit)
      dsel = par_en ? {par, buf_q[DW-2:0]} : buf_q;
    else
      dsel = {1'b1, (par_en ? par : buf_q[DW-2]), buf_q[DW-3:0]};
  end

  assign frame = {{(FW-DW-1){1'b1}}, dsel, 1'b0};
  assign pend  = busy | idle_q | brk_q | ~empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      empty_q <= 1'b1;
      busy    <= 1'b0;
      own     <= 1'b0;
      en_d    <= 1'b0;
      idle_q  <= 1'b0;
      brk_q   <= 1'b0;
      sh      <= '1;
      left    <= '0;
      tcnt    <= '0;
    end else begin
      en_d <= tx_en;
      own  <= tx_en | (own & pend);
      if (tx_en && !en_d && busy) idle_q <= 1'b1;
      if (brk_req && tx_en) brk_q <= 1'b1;
      if (busy) begin
        if (baud_tick) begin
          if (tcnt == CW'(OS - 1)) begin
            tcnt <= '0;
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - BW'(1);
            if (left == BW'(1)) busy <= 1'b0;
          end else begin
            tcnt <= tcnt + CW'(1);
          end
        end
      end else if (own) begin
        if (idle_q) begin
          sh     <= '1;
          left   <= flen;
          busy   <= 1'b1;
          tcnt   <= '0;
          idle_q <= 1'b0;
        end else if (brk_q) begin
          sh    <= {FW{1'b1}} << flen;
          left  <= flen + BW'(1);
          busy  <= 1'b1;
          tcnt  <= '0;
          brk_q <= 1'b0;
        end else if (!empty_q) begin
          sh      <= frame;
          left    <= flen;
          busy    <= 1'b1;
          tcnt    <= '0;
          empty_q <= 1'b1;
        end
      end
      if (wr_stb) begin
        buf_q   <= wr_data;
        empty_q <= 1'b0;
      end
    end
  end

  assign ser_out   = busy ? sh[0] : 1'b1;
  assign ser_oe    = loop_mode ? (rx_src & sw_dir & own) : own;
  assign buf_empty = empty_q;
  assign tx_done   = ~pend;
  assign irq_buf   = int_buf_en & empty_q;
  assign irq_done  = int_done_en & ~pend;
endmodule

module uart_tx_idleq_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_stb,
  input logic loop_mode,
  input logic rx_src,
  input logic int_buf_en,
  input logic ser_out,
  input logic ser_oe,
  input logic buf_empty,
  input logic tx_done,
  input logic irq_buf,
  input logic irq_done
);
  assert_write_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !buf_empty);
  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (ser_out && buf_empty));
  assert_hold_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && ser_oe && !tx_done && !loop_mode) |=> (ser_oe || loop_mode));
  assert_loop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && !rx_src) |-> !ser_oe);
  assert_buf_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !int_buf_en |-> !irq_buf);
  assert_done_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> tx_done);
endmodule

bind uart_tx_idleq uart_tx_idleq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb),
  .loop_mode(loop_mode), .rx_src(rx_src), .int_buf_en(int_buf_en),
  .ser_out(ser_out), .ser_oe(ser_oe), .buf_empty(buf_empty),
  .tx_done(tx_done), .irq_buf(irq_buf), .irq_done(irq_done)
);

// File: tb/uart_tx_idleq_tb.sv
module uart_tx_idleq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic baud_tick = 1'b1;
  logic tx_en = 0, par_en = 0, par_odd = 0, nine_bit = 0;
  logic loop_mode = 0, rx_src = 0, sw_dir = 0;
  logic int_buf_en = 0, int_done_en = 0, wr_stb = 0, brk_req = 0;
  logic [8:0] wr_data = '0;
  logic ser_out, ser_oe, buf_empty, tx_done, irq_buf, irq_done;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_idleq u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .par_en(par_en), .par_odd(par_odd), .nine_bit(nine_bit),
    .loop_mode(loop_mode), .rx_src(rx_src), .sw_dir(sw_dir),
    .int_buf_en(int_buf_en), .int_done_en(int_done_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .brk_req(brk_req), .ser_out(ser_out), .ser_oe(ser_oe),
    .buf_empty(buf_empty), .tx_done(tx_done), .irq_buf(irq_buf),
    .irq_done(irq_done)
  );

  // {nine_bit, par_en, par_odd, written value, expected data bits}
  localparam logic [20:0] VEC [0:6] = '{
    {1'b0, 1'b0, 1'b0, 9'h0A5, 9'h0A5},
    {1'b0, 1'b1, 1'b0, 9'h083, 9'h003},
    {1'b0, 1'b1, 1'b1, 9'h003, 9'h083},
    {1'b0, 1'b1, 1'b0, 9'h007, 9'h087},
    {1'b1, 1'b0, 1'b0, 9'h1FF, 9'h1FF},
    {1'b1, 1'b1, 1'b0, 9'h001, 9'h101},
    {1'b1, 1'b1, 1'b1, 9'h0F0, 9'h1F0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_buf(input logic [8:0] d);
    @(negedge clk); wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic find_start(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (ser_out == 1'b0) seen = 1'b1;
    end
  endtask

  task automatic grab(input int n, output logic [8:0] bits, output logic stopb);
    bit seen;
    bits = '0;
    find_start(seen);
    chk("R2 start seen", seen, 1);
    repeat (8) @(negedge clk);
    chk("R2 start bit", ser_out, 0);
    for (int i = 0; i < n; i++) begin
      repeat (16) @(negedge clk);
      bits[i] = ser_out;
    end
    repeat (16) @(negedge clk);
    stopb = ser_out;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [8:0] got;
    logic stopb;
    bit seen;
    int lowcnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ser_out", ser_out, 1);
    chk("R1 ser_oe", ser_oe, 0);
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 tx_done", tx_done, 1);
    chk("R1 irqs", {irq_buf, irq_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {ser_out, ser_oe, buf_empty, tx_done}, 4'b1011);

    tx_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      logic [20:0] v;
      v = VEC[i];
      nine_bit = v[20]; par_en = v[19]; par_odd = v[18];
      write_buf(v[17:9]);
      grab(v[20] ? 9 : 8, got, stopb);
      if (v[20]) chk("R2 R3 nine-bit data", got, v[8:0]);
      else       chk("R2 R3 eight-bit data", {1'b0, got[7:0]}, {1'b0, v[7:0]});
      chk("R2 stop bit", stopb, 1);
      repeat (20) @(negedge clk);
      chk("R5 done after frame", tx_done, 1);
    end
    nine_bit = 0; par_en = 0; par_odd = 0;

    // R6 idle queued by toggling the enable mid-frame
    write_buf(9'h055);
    find_start(seen);
    chk("R6 first start", seen, 1);
    wr_data = 9'h00E; wr_stb = 1'b1; tx_en = 1'b0;
    @(negedge clk); wr_stb = 1'b0; tx_en = 1'b1;
    repeat (6) @(negedge clk);
    for (int k = 1; k < 20; k++) begin
      repeat (16) @(negedge clk);
      if (k == 10) @(negedge clk);
      if (k >= 10) chk("R6 idle frame high", ser_out, 1);
    end
    repeat (17) @(negedge clk);
    chk("R6 data start after idle", ser_out, 0);
    repeat (16) @(negedge clk);
    chk("R6 data bit0", ser_out, 0);
    repeat (16) @(negedge clk);
    chk("R6 data bit1", ser_out, 1);
    repeat (200) @(negedge clk);
    chk("R6 done", tx_done, 1);

    // R7 ownership held after disable
    write_buf(9'h03C);
    find_start(seen);
    tx_en = 1'b0;
    repeat (8 + 16*5) @(negedge clk);
    chk("R7 oe held mid-frame", ser_oe, 1);
    chk("R7 data still sent", ser_out, 1);
    repeat (80) @(negedge clk);
    chk("R7 oe released", ser_oe, 0);
    chk("R7 line idle", ser_out, 1);

    // R4 R5 R10 buffer flag, completion and request gating
    write_buf(9'h012);
    chk("R4 write clears empty", buf_empty, 0);
    chk("R4 no load when not owned", ser_out, 1);
    chk("R5 done low with data queued", tx_done, 0);
    chk("R10 irq_buf masked", irq_buf, 0);
    int_buf_en = 1'b1; int_done_en = 1'b1;
    @(negedge clk);
    chk("R10 irq_buf low while full", irq_buf, 0);
    chk("R10 irq_done low while pending", irq_done, 0);
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 load sets empty", buf_empty, 1);
    chk("R10 irq_buf raised", irq_buf, 1);
    chk("R5 done low while shifting", tx_done, 0);
    repeat (170) @(negedge clk);
    chk("R5 done after shift", tx_done, 1);
    chk("R10 irq_done raised", irq_done, 1);
    int_buf_en = 1'b0; int_done_en = 1'b0;
    @(negedge clk);
    chk("R10 both masked", {irq_buf, irq_done}, 0);

    // R8 break
    for (int m = 0; m < 2; m++) begin
      nine_bit = m[0];
      @(negedge clk); brk_req = 1'b1;
      @(negedge clk); brk_req = 1'b0;
      find_start(seen);
      lowcnt = 1;
      while (ser_out == 1'b0 && lowcnt < 1000) begin
        @(negedge clk);
        if (ser_out == 1'b0) lowcnt++;
      end
      chk("R8 break low length", lowcnt, m ? 176 : 160);
      repeat (8) @(negedge clk);
      chk("R8 break stop high", ser_out, 1);
      repeat (20) @(negedge clk);
    end
    nine_bit = 0;

    // R9 loop and single-wire ownership
    loop_mode = 1'b1; rx_src = 1'b0; sw_dir = 1'b1;
    @(negedge clk);
    chk("R9 loop releases pin", ser_oe, 0);
    rx_src = 1'b1; sw_dir = 1'b0;
    @(negedge clk);
    chk("R9 single-wire input", ser_oe, 0);
    sw_dir = 1'b1;
    @(negedge clk);
    chk("R9 single-wire drive", ser_oe, 1);
    loop_mode = 1'b0;
    @(negedge clk);
    chk("R9 normal mode owns", ser_oe, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule